// File: doc/BRIEF.md
# Line Clock Reference Selector

This block decides which timing reference the jitter-attenuator loop of a dual-rail T1/E1 line interface follows. There are three choices:

- the clock recovered from the line;
- an external clock on the SYNC pin;
- the frequency-centered free-running state.

The block also raises the receive loss-of-signal flag. While that flag is raised, the two active-low receive data rails are held inactive.

All logic runs on a fast local clock. The recovered bit clock arrives as a one-cycle `bit_tick` strobe, together with the two receive rails sampled for that bit. A bit counts as a mark when either rail is low on its tick. The raw SYNC waveform is passed through a two-flop synchronizer. Its rising edges are counted in fixed windows of local-clock cycles to decide whether a SYNC clock is present. The expected SYNC rate is 2.048 MHz for E1 and 1.544 MHz for T1, both far below the local clock.

The reference FSM has three states:

- `ST_RECOV`: follow the recovered line clock.
- `ST_SYNC`: follow the SYNC clock.
- `ST_CENTER`: free-run, centered.

It has three transitions, each taken from any state on the next clock edge:

- `to_recov`: slave mode and no LOS.
- `to_sync`: a SYNC clock is present, and either master mode or slave mode with LOS.
- `to_center`: no SYNC clock, and either master mode or slave mode with LOS.

Master mode never looks at LOS. A separate registered output tells the receive-clock output mux whether to take the attenuated clock or the raw recovered clock.

Top module: `lcrs_top`

## Requirements
- R1: During and right after reset, `ref_sel` is 3'b100 (centered), `los` is 0 and `rclk_atten` is 0.
- R2: `los` becomes 1 in the clock cycle after the 32nd consecutive `bit_tick` with both rails high (no mark). It stays 0 after only 31 such ticks.
- R3: `los` returns to 0 in the clock cycle after the first `bit_tick` at which either rail is low.
- R4: While `los` is 1, `rd_pos_n` and `rd_neg_n` are both 1 whatever the rail inputs do. While `los` is 0, they follow `rx_pos_n_in` and `rx_neg_n_in` directly.
- R5: In slave mode (`master_sel`=0) with `los`=0, `ref_sel` becomes 3'b001 (recovered clock).
- R6: In slave mode with `los`=1, `ref_sel` becomes 3'b010 (SYNC) if a SYNC clock is present and 3'b100 (centered) if not.
- R7: In master mode (`master_sel`=1), `ref_sel` is 3'b010 if a SYNC clock is present and 3'b100 if not, whatever the value of `los`.
- R8: A SYNC clock becomes present after a window of 1024 local cycles that contains at least 4 synchronized rising edges. A window with 1 to 3 edges leaves the decision unchanged.
- R9: A SYNC clock becomes absent after a full window with no rising edge.
- R10: `ref_sel` is always exactly one-hot. It changes one clock cycle after the condition that selects it has been registered.
- R11: `rclk_atten` equals `jatt_en` delayed by one clock cycle. A value of 1 selects the attenuated clock and 0 selects the raw recovered clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per recovered bit period |
| rx_pos_n_in | input | 1 | Recovered positive-pulse rail, active low |
| rx_neg_n_in | input | 1 | Recovered negative-pulse rail, active low |
| sync_raw | input | 1 | Unsynchronized SYNC pin |
| master_sel | input | 1 | 1 = master, 0 = slave |
| jatt_en | input | 1 | 1 = jitter attenuator in use |
| ref_sel | output | 3 | One-hot reference: bit0 recovered, bit1 SYNC, bit2 centered |
| los | output | 1 | Receive loss of signal |
| rd_pos_n | output | 1 | Positive receive rail to the framer, active low |
| rd_neg_n | output | 1 | Negative receive rail to the framer, active low |
| rclk_atten | output | 1 | Receive clock output source: 1 attenuated, 0 raw |

## Verification
The assertions assume that `bit_tick` and the rails are synchronous to `clk` and are only meaningful on tick cycles. They also assume that `master_sel` and `jatt_en` are static control levels sampled on the local clock. The SYNC pin is the only asynchronous input. The stimulus changes every input half a period away from the rising edge, and it spaces ticks several cycles apart. It toggles SYNC well below half the local rate, so every edge survives the synchronizer. The edge-count boundary tests place their edges well inside one window, so a window boundary never splits them.

// File: rtl/lcrs_pkg.sv
package lcrs_pkg;
    typedef enum logic [1:0] {
        ST_CENTER = 2'd0,
        ST_SYNC   = 2'd1,
        ST_RECOV  = 2'd2
    } ref_state_t;

    localparam logic [2:0] SEL_RECOV  = 3'b001;
    localparam logic [2:0] SEL_SYNC   = 3'b010;
    localparam logic [2:0] SEL_CENTER = 3'b100;
endpackage

// File: rtl/lcrs_los_det.sv
module lcrs_los_det #(
    parameter int LOS_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic mark,
    output logic los
);
    localparam int CW = $clog2(LOS_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(LOS_BITS - 1);

    logic [CW-1:0] empty_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_cnt <= '0;
            los       <= 1'b0;
        end else if (bit_tick) begin
            if (mark) begin
                empty_cnt <= '0;
                los       <= 1'b0;
            end else if (empty_cnt == LAST) begin
                los       <= 1'b1;
            end else begin
                empty_cnt <= empty_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcrs_sync_act.sv
module lcrs_sync_act #(
    parameter int WIN       = 1024,
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    output logic sync_ok
);
    localparam int WW = $clog2(WIN);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [WW-1:0] WLAST = WW'(WIN - 1);
    localparam logic [EW:0]   NEED  = (EW+1)'(MIN_EDGES);

    logic          s1, s2, s3;
    logic          rise;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW:0]   edge_sum;

    assign rise     = s2 & ~s3;
    assign edge_sum = {1'b0, edge_cnt} + (EW+1)'(rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= sync_raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            sync_ok  <= 1'b0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
            if (win_cnt == WLAST) begin
                edge_cnt <= '0;
                if (edge_sum >= NEED)
                    sync_ok <= 1'b1;
                else if (edge_sum == '0)
                    sync_ok <= 1'b0;
            end else if (rise && ({1'b0, edge_cnt} < NEED)) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcrs_ref_fsm.sv
module lcrs_ref_fsm
    import lcrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_sel,
    input  logic       los,
    input  logic       sync_ok,
    output logic [2:0] ref_sel
);
    ref_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CENTER;
        else        state <= state_nx;
    end

    // to_recov / to_sync / to_center
    always_comb begin
        if (!master_sel && !los) state_nx = ST_RECOV;
        else if (sync_ok)        state_nx = ST_SYNC;
        else                     state_nx = ST_CENTER;
    end

    always_comb begin
        unique case (state)
            ST_RECOV: ref_sel = SEL_RECOV;
            ST_SYNC:  ref_sel = SEL_SYNC;
            default:  ref_sel = SEL_CENTER;
        endcase
    end
endmodule

// File: rtl/lcrs_top.sv
module lcrs_top #(
    parameter int LOS_BITS  = 32,
    parameter int WIN       = 1024,
    parameter int MIN_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       rx_pos_n_in,
    input  logic       rx_neg_n_in,
    input  logic       sync_raw,
    input  logic       master_sel,
    input  logic       jatt_en,
    output logic [2:0] ref_sel,
    output logic       los,
    output logic       rd_pos_n,
    output logic       rd_neg_n,
    output logic       rclk_atten
);
    logic mark;
    logic sync_ok;

    assign mark = ~rx_pos_n_in | ~rx_neg_n_in;

    lcrs_los_det #(.LOS_BITS(LOS_BITS)) u_los (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mark(mark), .los(los)
    );

    lcrs_sync_act #(.WIN(WIN), .MIN_EDGES(MIN_EDGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sync_raw(sync_raw), .sync_ok(sync_ok)
    );

    lcrs_ref_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .los(los),
        .sync_ok(sync_ok), .ref_sel(ref_sel)
    );

    assign rd_pos_n = los | rx_pos_n_in;
    assign rd_neg_n = los | rx_neg_n_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rclk_atten <= 1'b0;
        else        rclk_atten <= jatt_en;
    end
endmodule

// File: rtl/lcrs_chk.sv
module lcrs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       rx_pos_n_in,
    input logic       rx_neg_n_in,
    input logic       master_sel,
    input logic       jatt_en,
    input logic       sync_ok,
    input logic [2:0] ref_sel,
    input logic       los,
    input logic       rd_pos_n,
    input logic       rd_neg_n,
    input logic       rclk_atten
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ref_sel) == 1);

    // R4
    rails_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> (rd_pos_n && rd_neg_n));

    // R2
    los_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(los) |-> $past(bit_tick));

    // R3
    los_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bit_tick) && ($past(!rx_pos_n_in) || $past(!rx_neg_n_in)) |-> !los);

    // R5
    slave_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(master_sel) && !$past(los) |-> ref_sel == 3'b001);

    // R7
    master_center_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(master_sel) && !$past(sync_ok) |-> ref_sel == 3'b100);

    // R11
    atten_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> rclk_atten == $past(jatt_en));
endmodule

bind lcrs_top lcrs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_pos_n_in(rx_pos_n_in),
    .rx_neg_n_in(rx_neg_n_in), .master_sel(master_sel), .jatt_en(jatt_en),
    .sync_ok(sync_ok), .ref_sel(ref_sel), .los(los), .rd_pos_n(rd_pos_n),
    .rd_neg_n(rd_neg_n), .rclk_atten(rclk_atten)
);

// File: tb/sim_lcrs_top.sv
`timescale 1ns/1ps
module sim_lcrs_top;
    localparam int WIN = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_pos_n_in = 1'b1;
    logic       rx_neg_n_in = 1'b1;
    logic       sync_raw = 1'b0;
    logic       master_sel = 1'b0;
    logic       jatt_en = 1'b0;
    logic [2:0] ref_sel;
    logic       los, rd_pos_n, rd_neg_n, rclk_atten;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit sync_run = 1'b0;
    int tg = 0;

    always #2 clk = ~clk;

    lcrs_top u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_pos_n_in(rx_pos_n_in),
        .rx_neg_n_in(rx_neg_n_in), .sync_raw(sync_raw), .master_sel(master_sel),
        .jatt_en(jatt_en), .ref_sel(ref_sel), .los(los), .rd_pos_n(rd_pos_n),
        .rd_neg_n(rd_neg_n), .rclk_atten(rclk_atten)
    );

    always @(posedge clk) if (rst_n) cyc++;

    always @(negedge clk) begin
        if (sync_run) begin
            tg++;
            if (tg >= 4) begin
                sync_raw = ~sync_raw;
                tg = 0;
            end
        end
    end

    // {master, want_los, want_sync, expected ref_sel}
    localparam logic [5:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 3'b001},
        {1'b0, 1'b1, 1'b0, 3'b100},
        {1'b1, 1'b1, 1'b0, 3'b100},
        {1'b1, 1'b0, 1'b0, 3'b100},
        {1'b1, 1'b0, 1'b1, 3'b010},
        {1'b1, 1'b1, 1'b1, 3'b010},
        {1'b0, 1'b1, 1'b1, 3'b010},
        {1'b0, 1'b0, 1'b1, 3'b001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic pn, input logic nn);
        @(negedge clk);
        bit_tick = 1'b1; rx_pos_n_in = pn; rx_neg_n_in = nn;
        @(negedge clk);
        bit_tick = 1'b0; rx_pos_n_in = 1'b1; rx_neg_n_in = 1'b1;
    endtask

    task automatic empty_ticks(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        @(negedge clk);
        while ((cyc % WIN) != ph) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sync_raw = 1'b1; wait_cyc(4);
            sync_raw = 1'b0; wait_cyc(4);
        end
    endtask

    initial begin
        logic cur_sync;
        cur_sync = 1'b0;
        wait_cyc(3);
        // R1 reset state
        check("R1 ref_sel in reset", ref_sel, 3'b100);
        check("R1 los in reset", los, 1'b0);
        check("R1 rclk_atten in reset", rclk_atten, 1'b0);
        rst_n = 1'b1;
        wait_cyc(3);

        // Table walk: R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            master_sel = VEC[v][5];
            if (VEC[v][4] && !los) empty_ticks(32);
            if (!VEC[v][4] && los) tick(1'b0, 1'b1);
            if (VEC[v][3] != cur_sync) begin
                sync_run = VEC[v][3];
                if (!VEC[v][3]) sync_raw = 1'b0;
                cur_sync = VEC[v][3];
                wait_cyc(2 * WIN + 20);
            end
            wait_cyc(3);
            check(VEC[v][5] ? "R7 master table" : (VEC[v][4] ? "R6 slave los table" : "R5 slave table"),
                  ref_sel, VEC[v][2:0]);
        end
        sync_run = 1'b0; sync_raw = 1'b0;
        wait_cyc(2 * WIN + 20);

        // R2 boundary 31 vs 32, R10 one-cycle registration
        master_sel = 1'b0;
        tick(1'b0, 1'b1);
        wait_cyc(2);
        check("R5 slave recovered", ref_sel, 3'b001);
        empty_ticks(31);
        check("R2 no los after 31", los, 1'b0);
        tick(1'b1, 1'b1);
        check("R2 los after 32", los, 1'b1);
        check("R10 select not yet moved", ref_sel, 3'b001);
        wait_cyc(1);
        check("R10 select moved to centered", ref_sel, 3'b100);

        // R4 forcing while los
        rx_pos_n_in = 1'b0; rx_neg_n_in = 1'b0;
        #0.5;
        check("R4 pos rail forced", rd_pos_n, 1'b1);
        check("R4 neg rail forced", rd_neg_n, 1'b1);
        rx_pos_n_in = 1'b1; rx_neg_n_in = 1'b1;

        // R7 master ignores los change
        master_sel = 1'b1;
        wait_cyc(2);
        tick(1'b1, 1'b0);
        check("R3 los cleared by mark", los, 1'b0);
        wait_cyc(2);
        check("R7 master ignores los", ref_sel, 3'b100);

        // R4 passthrough
        @(negedge clk);
        rx_neg_n_in = 1'b0;
        #0.5;
        check("R4 neg rail follows", rd_neg_n, 1'b0);
        check("R4 pos rail follows", rd_pos_n, 1'b1);
        rx_neg_n_in = 1'b1;

        // R8 three edges keep absent
        wait_phase(100);
        pulses(3);
        wait_phase(50);
        wait_cyc(5);
        check("R8 three edges not enough", ref_sel, 3'b100);
        // R8 four edges make present
        wait_phase(100);
        pulses(4);
        wait_phase(50);
        wait_cyc(5);
        check("R8 four edges present", ref_sel, 3'b010);
        // R8 three edges keep present (hold)
        wait_phase(100);
        pulses(3);
        wait_phase(50);
        wait_cyc(5);
        check("R8 partial window holds", ref_sel, 3'b010);
        // R9 empty window makes absent
        wait_cyc(WIN + 20);
        check("R9 empty window absent", ref_sel, 3'b100);

        // R11
        @(negedge clk);
        jatt_en = 1'b1;
        @(negedge clk);
        check("R11 attenuated source", rclk_atten, 1'b1);
        jatt_en = 1'b0;
        @(negedge clk);
        check("R11 raw source", rclk_atten, 1'b0);

        // R1 mid-run reset
        jatt_en = 1'b1; master_sel = 1'b0;
        empty_ticks(32);
        rst_n = 1'b0;
        #0.5;
        check("R1 los after reset", los, 1'b0);
        check("R1 ref_sel after reset", ref_sel, 3'b100);
        check("R1 rclk_atten after reset", rclk_atten, 1'b0);
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R5 recovered after reset", ref_sel, 3'b001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule